// File: doc/BRIEF.md
# Single-Digit Decimal Multiplier

This block multiplies two decimal digits, each carried as a 4-bit binary-coded value from 0 to 9, and returns their product as two decimal digits in one byte: the tens digit in the upper nibble and the units digit in the lower nibble. It is purely combinational. Every product bit is formed by its own logic function of the eight operand bits. No binary product is built and later converted to decimal, and neither operand is recoded.

Internally each operand is decoded into ten digit-select lines. Each product bit is then an OR over the digit pairs whose product has that bit set. The pair sets are worked out at elaboration from the radix, so no hand-written table exists. Two bits have short forms: the units least significant bit needs only the two operand low bits, and the tens most significant bit needs only four operand bits. A range checker flags any operand above 9. While that flag is high the product is held at zero.

The block is meant as the digit-by-digit partial-product cell of a wider decimal multiplier.

Top module: `bcdmul_digit`

## Requirements
- R1: For every pair of operands both in 0..9, `product[7:4]` equals (opA*opB)/10 and `product[3:0]` equals (opA*opB) mod 10, each as a plain 4-bit binary value.
- R2: opA=6 and opB=8 give product 8'b0100_1000 (48).
- R3: opA=9 and opB=9 give product 8'b1000_0001 (81).
- R4: With valid operands, both product nibbles are at most 9.
- R5: `invalid` is 1 exactly when opA > 9 or opB > 9, and 0 otherwise.
- R6: While `invalid` is 1, product is 8'h00.
- R7: With valid operands, a zero in either operand gives product 8'h00.
- R8: With valid operands, opA=1 gives product {4'h0, opB}, and opB=1 gives product {4'h0, opA}.
- R9: With valid operands, product bit 0 equals opA[0] AND opB[0].
- R10: With valid operands, product bit 7 is 1 only for the pair 9 by 9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 4 | First decimal digit, binary coded |
| opB | input | 4 | Second decimal digit, binary coded |
| product | output | 8 | Two-digit decimal product, tens digit in [7:4], units digit in [3:0] |
| invalid | output | 1 | High when either operand is above 9 |

## Verification
The hardest case to reach is the one pair, 9 by 9, that sets the top product bit. Product bit 1 is also hard because it depends on all eight operand bits, so a fault in it can stay hidden until one particular pair is applied. For this reason the stimulus sweeps all 256 operand codes, each held for one clock, and compares against an integer reference built from the requirements. All 156 codes with an operand above 9 are included, so the zeroing and flag behaviour are covered completely.

// File: rtl/bcdmul_pkg.sv
package bcdmul_pkg;

  // Range flags passed from the control side to the datapath
  typedef struct packed {
    logic aOver;   // first operand above the largest digit
    logic bOver;   // second operand above the largest digit
  } mulStrobe_t;

endpackage

// File: rtl/bcdmul_ctrl.sv
module bcdmul_ctrl
  import bcdmul_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int RADIX   = 10
) (
  input  logic [DIGIT_W-1:0] opA,
  input  logic [DIGIT_W-1:0] opB,
  output mulStrobe_t         strobe,
  output logic               invalid
);

  localparam logic [DIGIT_W-1:0] MAX_DIGIT = DIGIT_W'(RADIX - 1);

  always_comb begin
    strobe.aOver = (opA > MAX_DIGIT);
    strobe.bOver = (opB > MAX_DIGIT);
    invalid      = strobe.aOver | strobe.bOver;
  end

endmodule

// File: rtl/bcdmul_datapath.sv
module bcdmul_datapath
  import bcdmul_pkg::*;
#(
  parameter int DIGIT_W   = 4,
  parameter int RADIX     = 10,
  parameter bit TRIM_BITS = 1'b1
) (
  input  logic [DIGIT_W-1:0]   opA,
  input  logic [DIGIT_W-1:0]   opB,
  input  mulStrobe_t           strobe,
  output logic [2*DIGIT_W-1:0] product
);

  localparam int OUT_W  = 2 * DIGIT_W;
  localparam int PAIRS  = RADIX * RADIX;
  localparam bit SHORTS = TRIM_BITS && (RADIX == 10) && (DIGIT_W == 4);

  // Set of digit pairs whose two-digit product has bit bitIdx high
  function automatic logic [PAIRS-1:0] makeMask(int bitIdx);
    logic [PAIRS-1:0] m;
    int prodVal;
    int digitVal;
    m = '0;
    for (int i = 0; i < RADIX; i++) begin
      for (int j = 0; j < RADIX; j++) begin
        prodVal = i * j;
        if (bitIdx < DIGIT_W) digitVal = prodVal % RADIX;
        else                  digitVal = prodVal / RADIX;
        m[i*RADIX + j] = digitVal[bitIdx % DIGIT_W];
      end
    end
    return m;
  endfunction

  logic [RADIX-1:0] aHot;
  logic [RADIX-1:0] bHot;
  logic [OUT_W-1:0] rawBits;

  // Digit-select decoders
  for (genvar d = 0; d < RADIX; d++) begin : g_dec
    assign aHot[d] = (opA == DIGIT_W'(d));
    assign bHot[d] = (opB == DIGIT_W'(d));
  end

  // One OR plane per product bit, or a short form where it applies
  for (genvar k = 0; k < OUT_W; k++) begin : g_bit
    if (SHORTS && k == 0) begin : g_short_lo
      assign rawBits[k] = opA[0] & opB[0];
    end else if (SHORTS && k == OUT_W - 1) begin : g_short_hi
      assign rawBits[k] = opA[3] & opA[0] & opB[3] & opB[0];
    end else begin : g_plane
      localparam logic [PAIRS-1:0] BIT_MASK = makeMask(k);
      logic [PAIRS-1:0] term;
      for (genvar i = 0; i < RADIX; i++) begin : g_row
        for (genvar j = 0; j < RADIX; j++) begin : g_col
          if (BIT_MASK[i*RADIX + j]) begin : g_on
            assign term[i*RADIX + j] = aHot[i] & bHot[j];
          end else begin : g_off
            assign term[i*RADIX + j] = 1'b0;
          end
        end
      end
      assign rawBits[k] = |term;
    end
  end

  assign product = (strobe.aOver | strobe.bOver) ? '0 : rawBits;

  // Decoders never select two digits at once (supports R1)
  always_comb begin
    p_dec_onehot_r1: assert ($onehot0(aHot) && $onehot0(bHot))
      else $error("digit decoder selected more than one line");
  end

endmodule

// File: rtl/bcdmul_digit.sv
module bcdmul_digit
  import bcdmul_pkg::*;
#(
  parameter int DIGIT_W   = 4,
  parameter int RADIX     = 10,
  parameter bit TRIM_BITS = 1'b1
) (
  input  logic [DIGIT_W-1:0]   opA,
  input  logic [DIGIT_W-1:0]   opB,
  output logic [2*DIGIT_W-1:0] product,
  output logic                 invalid
);

  mulStrobe_t strobe;

  bcdmul_ctrl #(
    .DIGIT_W(DIGIT_W),
    .RADIX  (RADIX)
  ) u_ctrl (
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe),
    .invalid(invalid)
  );

  bcdmul_datapath #(
    .DIGIT_W  (DIGIT_W),
    .RADIX    (RADIX),
    .TRIM_BITS(TRIM_BITS)
  ) u_dp (
    .opA    (opA),
    .opB    (opB),
    .strobe (strobe),
    .product(product)
  );

  localparam logic [DIGIT_W-1:0] TOP_DIGIT = DIGIT_W'(RADIX - 1);

  always_comb begin
    if (!invalid) begin
      p_digit_range_r4: assert (product[DIGIT_W-1:0] <= TOP_DIGIT &&
                                product[2*DIGIT_W-1:DIGIT_W] <= TOP_DIGIT)
        else $error("product digit out of range");
      p_zero_factor_r7: assert (!(opA == '0 || opB == '0) || product == '0)
        else $error("zero operand gave nonzero product");
      p_unit_factor_r8: assert (opA != DIGIT_W'(1) || product == {{DIGIT_W{1'b0}}, opB})
        else $error("unit operand did not pass the other digit");
      p_low_bit_r9: assert (product[0] == (opA[0] & opB[0]))
        else $error("units low bit mismatch");
      p_top_bit_r10: assert (!product[2*DIGIT_W-1] ||
                             (opA == TOP_DIGIT && opB == TOP_DIGIT))
        else $error("tens top bit set for a pair other than the largest");
    end else begin
      p_zero_when_bad_r6: assert (product == '0)
        else $error("product not cleared for out-of-range operand");
    end
  end

endmodule

// File: tb/sim_bcdmul_digit.sv
module sim_bcdmul_digit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] opA = 4'd0;
  logic [3:0] opB = 4'd0;
  logic [7:0] product;
  logic       invalid;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  bcdmul_digit u0 (
    .opA    (opA),
    .opB    (opB),
    .product(product),
    .invalid(invalid)
  );

  task automatic check8(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s a=%0d b=%0d actual=%h expected=%h", req, opA, opB, act, exp);
    end
  endtask

  task automatic apply(int a, int b);
    @(posedge clk);
    opA = 4'(a);
    opB = 4'(b);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    int refProd;
    logic [7:0] expP;
    logic expBad;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle state with zero operands (R7)
    check8("R7 idle", product, 8'h00);
    check8("R5 idle", {7'd0, invalid}, 8'h00);

    // Named corner cases
    apply(6, 8); check8("R2", product, 8'h48);
    apply(9, 9); check8("R3", product, 8'h81);
    apply(9, 9); check8("R10 top bit", {7'd0, product[7]}, 8'h01);
    apply(8, 9); check8("R10 top bit", {7'd0, product[7]}, 8'h00);
    apply(0, 7); check8("R7", product, 8'h00);
    apply(5, 0); check8("R7", product, 8'h00);
    apply(1, 9); check8("R8", product, 8'h09);
    apply(7, 1); check8("R8", product, 8'h07);
    apply(7, 3); check8("R9", {7'd0, product[0]}, 8'h01);
    apply(15, 15); check8("R6", product, 8'h00);
    apply(10, 3);  check8("R5", {7'd0, invalid}, 8'h01);

    // Exhaustive sweep against the integer reference (R1, R4, R5, R6)
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        apply(a, b);
        expBad = (a > 9) || (b > 9);
        check8("R5", {7'd0, invalid}, {7'd0, expBad});
        if (expBad) begin
          check8("R6", product, 8'h00);
        end else begin
          refProd = a * b;
          expP = {4'(refProd / 10), 4'(refProd % 10)};
          check8("R1", product, expP);
          checks++;
          if (product[7:4] > 4'd9 || product[3:0] > 4'd9) begin
            failures++;
            $display("FAIL R4 a=%0d b=%0d actual=%h expected=digits<=9", a, b, product);
          end
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

endmodule